// File: doc/BRIEF.md
# Shared-Bus Arbiter with Preference and Deny Controls

This block decides which of five masters owns a shared system bus. The masters are an expansion bus bridge (index 0), a core I/O bridge (index 1), two system-connect slots (indices 2 and 3) and the CPU (index 4). Each master raises its bit of `req`. The arbiter answers with a registered one-hot `gnt`. A grant stays with its owner until that owner drops its request. A new winner is picked only when the bus is idle or when the owner lets go.

A small configuration register controls the arbitration. It holds a deny bit for each of the four non-CPU masters and a prefer bit for every master. A denied master is never handed the bus. At most one master may be preferred. A preferred master that is requesting wins every second arbitration, and the arbitrations in between are shared round-robin among all eligible masters. Software writes the register through a write strobe and data port and reads it back in full. Two summary outputs report whether any prefer bit or any deny bit is set.

Top module: `pref_bus_arbiter`

## Requirements
- R1: After reset, `gnt` is 0, `cfg_rdata` is 0x055 (every deny bit set, every prefer bit clear), `cfg_bad_wr` is 0, `deny_any` is 1 and `pref_any` is 0.
- R2: Configuration layout: bit 2i is the deny bit of master i (i = 0..3), bit 2i+1 is the prefer bit of master i (i = 0..4), so the CPU prefer bit is bit 9. Bit 8 is unused, ignores writes and reads 0. A legal write shows on `cfg_rdata` in the cycle after `cfg_we`.
- R3: A write whose data has more than one prefer bit set keeps the previous prefer bits, takes the new deny bits, and pulses `cfg_bad_wr` high for exactly the following cycle. Any other write leaves `cfg_bad_wr` low.
- R4: `pref_any` is 1 exactly when `cfg_rdata & 0x2AA` is nonzero. `deny_any` is 1 exactly when `cfg_rdata & 0x055` is nonzero.
- R5: A master whose deny bit is set in the cycle of an arbitration is not granted by that arbitration.
- R6: `gnt` is always zero or one-hot. While the owner keeps its request high, `gnt` does not change.
- R7: An arbitration happens in every cycle in which no granted master is requesting. Its result appears on `gnt` one cycle later. If no master is eligible, the result is all zeros.
- R8: When the preferred master does not win, the winner is the first eligible master found by scanning upward (wrapping from 4 to 0) from the index after the last master granted. After reset the scan starts at master 0.
- R9: A slot-parity flag starts in the preference state after reset and toggles on every arbitration that issues a grant. In the preference state, an eligible preferred master wins.
- R10: The CPU (index 4) has no deny bit and is always eligible when it requests. It wins when it is the only eligible requester, even while every other master is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 5 | Bus request per master |
| gnt | output | 5 | Registered one-hot bus grant |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 10 | Configuration write data |
| cfg_rdata | output | 10 | Configuration register contents |
| cfg_bad_wr | output | 1 | One-cycle flag for a write with multiple prefer bits |
| pref_any | output | 1 | Some prefer bit is set |
| deny_any | output | 1 | Some deny bit is set |

## Verification
The bench builds the arbiter with the default of five masters. At that size, the unused bit 8 and the CPU prefer bit 9 sit where the layout in R2 places them, and the round-robin wrap from master 4 back to master 0 occurs often. Random request patterns mixed with random writes bring about all of the following: owner release and immediate rearbitration, the alternation between preference and round-robin arbitrations while a single master is preferred, and grants being withheld from denied masters. Directed steps cover the reset image, a CPU-only grant under full deny, the unused bit, and rejected multi-prefer writes.

// File: rtl/pba_pkg.sv
package pba_pkg;
  localparam int unsigned NREQ_DEF = 5;

  function automatic int unsigned deny_bit(input int unsigned i);
    return 2 * i;
  endfunction

  function automatic int unsigned pref_bit(input int unsigned i);
    return 2 * i + 1;
  endfunction
endpackage

// File: rtl/pba_cfg_reg.sv
module pba_cfg_reg #(
  parameter int unsigned N  = pba_pkg::NREQ_DEF,
  localparam int unsigned CW = 2 * N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] q,
  output logic [N-1:0]  deny,
  output logic [N-1:0]  pref,
  output logic          bad
);
  function automatic logic [CW-1:0] mk_deny_mask();
    logic [CW-1:0] m;
    m = '0;
    for (int i = 0; i < int'(N) - 1; i++) m[pba_pkg::deny_bit(i)] = 1'b1;
    return m;
  endfunction

  function automatic logic [CW-1:0] mk_pref_mask();
    logic [CW-1:0] m;
    m = '0;
    for (int i = 0; i < int'(N); i++) m[pba_pkg::pref_bit(i)] = 1'b1;
    return m;
  endfunction

  localparam logic [CW-1:0] DENY_M = mk_deny_mask();
  localparam logic [CW-1:0] PREF_M = mk_pref_mask();
  localparam logic [CW-1:0] WR_M   = DENY_M | PREF_M;

  logic [N-1:0] wpref;
  logic         multi;

  for (genvar i = 0; i < int'(N); i++) begin : g_fields
    assign wpref[i] = wdata[2*i+1];
    assign pref[i]  = q[2*i+1];
    if (i < int'(N) - 1) begin : g_den
      assign deny[i] = q[2*i];
    end else begin : g_cpu
      assign deny[i] = 1'b0;
    end
  end

  assign multi = $countones(wpref) > 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= DENY_M;
      bad <= 1'b0;
    end else begin
      bad <= we && multi;
      if (we) begin
        if (multi) q <= (q & PREF_M) | (wdata & DENY_M);
        else       q <= wdata & WR_M;
      end
    end
  end
endmodule

// File: rtl/pba_rr_pick.sv
module pba_rr_pick #(
  parameter int unsigned N  = pba_pkg::NREQ_DEF,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  elig,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] idx
);
  int c;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    c     = 0;
    for (int k = 1; k <= int'(N); k++) begin
      c = (int'(last) + k) % int'(N);
      if (!found && elig[c]) begin
        found = 1'b1;
        idx   = IW'(c);
      end
    end
  end
endmodule

// File: rtl/pref_bus_arbiter.sv
module pref_bus_arbiter #(
  parameter int unsigned NUM_REQ = pba_pkg::NREQ_DEF,
  localparam int unsigned CW = 2 * NUM_REQ,
  localparam int unsigned IW = $clog2(NUM_REQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] req,
  output logic [NUM_REQ-1:0] gnt,
  input  logic               cfg_we,
  input  logic [CW-1:0]      cfg_wdata,
  output logic [CW-1:0]      cfg_rdata,
  output logic               cfg_bad_wr,
  output logic               pref_any,
  output logic               deny_any
);
  logic [NUM_REQ-1:0] deny, pref, elig, pref_hit;
  logic               owner_req, arb, pref_go, rr_found, any_elig;
  logic [IW-1:0]      rr_idx, p_idx, win_idx, last_q;
  logic               pref_turn_q;

  pba_cfg_reg #(.N(NUM_REQ)) u_cfg (
    .clk  (clk),
    .rst  (rst),
    .we   (cfg_we),
    .wdata(cfg_wdata),
    .q    (cfg_rdata),
    .deny (deny),
    .pref (pref),
    .bad  (cfg_bad_wr)
  );

  assign pref_any = |pref;
  assign deny_any = |deny;

  assign elig      = req & ~deny;
  assign any_elig  = |elig;
  assign owner_req = |(gnt & req);
  assign arb       = !owner_req;
  assign pref_hit  = pref & elig;
  assign pref_go   = pref_turn_q && (|pref_hit);

  always_comb begin
    p_idx = '0;
    for (int i = 0; i < int'(NUM_REQ); i++)
      if (pref_hit[i]) p_idx = IW'(i);
  end

  pba_rr_pick #(.N(NUM_REQ)) u_rr (
    .elig (elig),
    .last (last_q),
    .found(rr_found),
    .idx  (rr_idx)
  );

  assign win_idx = pref_go ? p_idx : rr_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt         <= '0;
      pref_turn_q <= 1'b1;
      last_q      <= IW'(NUM_REQ - 1);
    end else if (arb) begin
      if (any_elig && (pref_go || rr_found)) begin
        gnt         <= NUM_REQ'(1) << win_idx;
        pref_turn_q <= !pref_turn_q;
        last_q      <= win_idx;
      end else begin
        gnt <= '0;
      end
    end
  end
endmodule

// File: rtl/pba_chk.sv
module pba_chk #(
  parameter int unsigned N  = pba_pkg::NREQ_DEF,
  localparam int unsigned CW = 2 * N
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  req,
  input logic [N-1:0]  gnt,
  input logic          cfg_we,
  input logic [CW-1:0] cfg_wdata,
  input logic [CW-1:0] cfg_rdata,
  input logic          cfg_bad_wr
);
  function automatic logic [N-1:0] prefs(input logic [CW-1:0] v);
    logic [N-1:0] p;
    for (int i = 0; i < int'(N); i++) p[i] = v[2*i+1];
    return p;
  endfunction

  a_r6_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (|(gnt & req)) |=> $stable(gnt));

  a_r2_unused_bit: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[CW-2] == 1'b0);

  a_r3_multi_pref_kept: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && ($countones(prefs(cfg_wdata)) > 1))
      |=> (cfg_bad_wr && (prefs(cfg_rdata) == $past(prefs(cfg_rdata)))));

  for (genvar i = 0; i < int'(N) - 1; i++) begin : g_deny
    a_r5_no_denied_grant: assert property (@(posedge clk) disable iff (rst)
      (!gnt[i] && cfg_rdata[2*i]) |=> !gnt[i]);
  end
endmodule

bind pref_bus_arbiter pba_chk #(.N(NUM_REQ)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req       (req),
  .gnt       (gnt),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .cfg_bad_wr(cfg_bad_wr)
);

// File: tb/pref_bus_arbiter_test.sv
`timescale 1ns/1ps
module pref_bus_arbiter_test;
  localparam int N  = 5;
  localparam int CW = 10;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  req;
  logic [N-1:0]  gnt;
  logic          cfg_we;
  logic [CW-1:0] cfg_wdata;
  logic [CW-1:0] cfg_rdata;
  logic          cfg_bad_wr, pref_any, deny_any;

  always #2 clk = ~clk;

  pref_bus_arbiter uut (
    .clk(clk), .rst(rst), .req(req), .gnt(gnt),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_bad_wr(cfg_bad_wr), .pref_any(pref_any), .deny_any(deny_any)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string tag;

  // reference state built from the requirements
  logic [CW-1:0] m_cfg;
  logic [N-1:0]  m_gnt;
  logic          m_turn, m_bad;
  int            m_last;

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R6 R7 gnt", 16'(gnt), 16'(m_gnt));
    chk("R2 cfg_rdata", 16'(cfg_rdata), 16'(m_cfg));
    chk("R3 cfg_bad_wr", 16'(cfg_bad_wr), 16'(m_bad));
    chk("R4 pref_any", 16'(pref_any), 16'(|(m_cfg & 10'h2AA)));
    chk("R4 deny_any", 16'(deny_any), 16'(|(m_cfg & 10'h055)));
  endtask

  task automatic model_step(input logic [N-1:0] r, input logic we, input logic [CW-1:0] wd);
    logic [N-1:0] dn, pf, el;
    int win, np;
    dn = {1'b0, m_cfg[6], m_cfg[4], m_cfg[2], m_cfg[0]};
    pf = {m_cfg[9], m_cfg[7], m_cfg[5], m_cfg[3], m_cfg[1]};
    el = r & ~dn;
    if ((m_gnt & r) == '0) begin
      if (el != '0) begin
        win = -1;
        if (m_turn && ((pf & el) != '0))
          for (int i = 0; i < N; i++) if (pf[i] && el[i]) win = i;
        if (win < 0)
          for (int k = 1; k <= N; k++)
            if (win < 0 && el[(m_last + k) % N]) win = (m_last + k) % N;
        m_gnt  = N'(1) << win;
        m_turn = !m_turn;
        m_last = win;
      end else begin
        m_gnt = '0;
      end
    end
    np = int'(wd[1]) + int'(wd[3]) + int'(wd[5]) + int'(wd[7]) + int'(wd[9]);
    m_bad = we && (np > 1);
    if (we) begin
      if (np > 1) m_cfg = (m_cfg & 10'h2AA) | (wd & 10'h055);
      else        m_cfg = wd & 10'h2FF;
    end
  endtask

  task automatic step(input logic [N-1:0] r, input logic we, input logic [CW-1:0] wd);
    req = r; cfg_we = we; cfg_wdata = wd;
    model_step(r, we, wd);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    logic [CW-1:0] wd;
    void'($urandom(32'd20240611));
    rst = 1'b1; req = '0; cfg_we = 1'b0; cfg_wdata = '0;
    m_cfg = 10'h055; m_gnt = '0; m_turn = 1'b1; m_bad = 1'b0; m_last = N - 1;
    repeat (3) @(negedge clk);
    tag = "R1 reset";
    compare_all();
    chk("R1 reset image", 16'(cfg_rdata), 16'h0055);
    rst = 1'b0;

    tag = "R10 cpu only under deny";
    step(5'b11111, 1'b0, '0);
    chk("R10 cpu granted", 16'(gnt), 16'h0010);
    step(5'b01111, 1'b0, '0);
    chk("R7 idle after release", 16'(gnt), 16'h0000);

    tag = "R2 unused bit";
    step(5'b00000, 1'b1, 10'h100);
    step(5'b00000, 1'b0, '0);
    chk("R2 bit8 reads zero", 16'(cfg_rdata), 16'h0000);

    tag = "R8 round robin";
    step(5'b11111, 1'b0, '0);
    step(5'b11110, 1'b0, '0);
    step(5'b11101, 1'b0, '0);
    step(5'b11011, 1'b0, '0);

    tag = "R9 preference slots";
    step(5'b00000, 1'b1, 10'h008);
    for (int i = 0; i < 12; i++)
      step(gnt == '0 ? 5'b11111 : ~gnt, 1'b0, '0);

    tag = "R3 multi prefer write";
    step(5'b00000, 1'b1, 10'h3FF);
    chk("R3 bad flag", 16'(cfg_bad_wr), 16'h0001);
    step(5'b00000, 1'b0, '0);
    chk("R3 flag one cycle", 16'(cfg_bad_wr), 16'h0000);

    tag = "R5 deny subset";
    step(5'b00000, 1'b1, 10'h015);
    for (int i = 0; i < 10; i++)
      step(gnt == '0 ? 5'b11111 : ~gnt, 1'b0, '0);

    tag = "R5 R8 R9 random";
    for (int i = 0; i < 4000; i++) begin
      wd = 10'($urandom);
      if ($urandom_range(0, 1) == 0) begin
        wd = wd & 10'h155;
        if ($urandom_range(0, 1) == 0) wd[2*$urandom_range(0, 4)+1] = 1'b1;
      end
      step(5'($urandom), $urandom_range(0, 15) == 0, wd);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: got hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule